// File: doc/BRIEF.md
# Block Data Transfer Sequencer

This block moves the data phase of a card transfer between a 16-bit host FIFO and a byte-wide card data port. A data command elsewhere in the chip pulses `start` and gives the direction. In receive mode the block takes bytes from the card stream and packs them in pairs into FIFO words. In transmit mode it takes FIFO words and sends them to the card one byte at a time. It counts the bytes of each block and the blocks of the transfer. When the last block ends, it drops its active flag and pulses a completion strobe.

Software programs the block length and the block count through two write strobes that share one data bus. Both values are written as "value minus one" in an 11-bit field. The two readback ports return the live remaining counters, not the programmed values. At the end of each block the byte counter reloads by itself. At the end of the transfer the block counter reloads by itself, so a repeat transfer with the same geometry needs no reprogramming.

Both card streams use valid/ready. A byte moves only on a cycle where valid and ready are both high, and at most one byte moves per clock. On the receive side, `rx_ready` is the block's back-pressure. At a word boundary it stays low while the FIFO level is above the almost-full threshold. On the transmit side, `tx_valid` stays low while the FIFO is empty. Once `tx_valid` is high with `tx_ready` low, it holds `tx_valid` high and `tx_data` unchanged until the byte is taken.

Top module: `blk_xfer_seq`

## Requirements
- R1: A `len_wr` pulse stores `reg_wdata[10:0] + 1` as the block length and loads the byte counter with it. Bits 15:11 are ignored, so a written value of 0x07FF gives 2048.
- R2: A `cnt_wr` pulse stores `reg_wdata[10:0] + 1` as the block count and loads the block counter with it. It also reloads the byte counter from the stored block length.
- R3: In receive mode, the first card byte of a word goes to bits 7:0 of `fifo_wdata` and the second to bits 15:8. The word is pushed with `fifo_push` on the cycle its last byte is accepted. When a block has an odd length, its final byte is pushed alone, with bits 15:8 zero.
- R4: In transmit mode, bits 7:0 of `fifo_head` go out first, then bits 15:8 if the block still has bytes left. `fifo_pop` is pulsed on the cycle the word's last byte is taken. A block's odd final byte takes a whole word and pops it after the low byte.
- R5: In receive mode, at a word boundary (an even number of bytes taken in the current block), `rx_ready` is low whenever `fifo_level` > `af_level`, and high otherwise.
- R6: In transmit mode, `tx_valid` is low whenever `fifo_empty` is high at a word boundary.
- R7: Each byte moved lowers the byte counter by one. When it would reach zero, it reloads from the block length and the block counter drops by one.
- R8: On the transfer's last byte, the block counter reloads from the block count, `xfer_active` falls, and `xfer_done` is high for exactly the next cycle.
- R9: While `xfer_active` is low, `rx_ready`, `tx_valid`, `fifo_push` and `fifo_pop` stay low, and the counters keep their values.
- R10: A stalled transmit byte (`tx_valid` high, `tx_ready` low) stays valid with unchanged `tx_data` on the next cycle.
- R11: `blen_live` and `nblk_live` always show the remaining bytes in the current block and the remaining blocks, including the current block.
- R12: After reset, all counters, lengths and flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that starts a transfer |
| start_rx | input | 1 | Direction with `start`: 1 card to FIFO, 0 FIFO to card |
| len_wr | input | 1 | Write strobe for the block length |
| cnt_wr | input | 1 | Write strobe for the block count |
| reg_wdata | input | 16 | Register write data (bits 10:0 used) |
| blen_live | output | 12 | Remaining bytes in the current block |
| nblk_live | output | 12 | Remaining blocks |
| xfer_active | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle completion strobe |
| fifo_level | input | 6 | Current FIFO fill in words |
| af_level | input | 5 | Almost-full threshold |
| fifo_push | output | 1 | Push strobe (receive) |
| fifo_wdata | output | 16 | Word to push |
| fifo_empty | input | 1 | FIFO holds no words |
| fifo_head | input | 16 | Word at the FIFO head |
| fifo_pop | output | 1 | Pop strobe (transmit) |
| rx_valid | input | 1 | Card byte available |
| rx_data | input | 8 | Card byte |
| rx_ready | output | 1 | Block accepts the card byte |
| tx_valid | output | 1 | Byte offered to the card |
| tx_data | output | 8 | Byte to the card |
| tx_ready | input | 1 | Card accepts the byte |

## Verification
The main function is exercised with several block lengths: even, odd and length one. These tell apart correct pairing from an odd final byte left to share a word with the next block. Block counts of one and several show whether the byte counter reloads without ending the transfer too early. Random card-side valid/ready stalls show whether bytes are lost or duplicated under back-pressure. A slowly drained FIFO with a low threshold, and a starved FIFO on transmit, show whether the pause decision is taken only at word boundaries. Idle stimulus before a start shows that the block ignores the card stream until a transfer is active.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/blk_len_ctr.sv
module blk_len_ctr #(
  parameter int FIELD_W = 11,
  localparam int CNT_W = FIELD_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               len_wr,
  input  logic               cnt_wr,
  input  logic [FIELD_W-1:0] wr_field,
  input  logic               step,
  output logic [CNT_W-1:0]   bcnt_o,
  output logic [CNT_W-1:0]   ncnt_o,
  output logic               last_byte,
  output logic               last_blk
);
  logic [CNT_W-1:0] blen_q, nblk_q, bcnt_q, ncnt_q;
  logic [CNT_W-1:0] wr_plus1;

  assign wr_plus1  = {1'b0, wr_field} + CNT_W'(1);
  assign last_byte = (bcnt_q == CNT_W'(1));
  assign last_blk  = (ncnt_q == CNT_W'(1));
  assign bcnt_o    = bcnt_q;
  assign ncnt_o    = ncnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blen_q <= '0;
      nblk_q <= '0;
      bcnt_q <= '0;
      ncnt_q <= '0;
    end else begin
      if (step) begin
        if (last_byte) begin
          bcnt_q <= blen_q;
          ncnt_q <= last_blk ? nblk_q : ncnt_q - CNT_W'(1);
        end else begin
          bcnt_q <= bcnt_q - CNT_W'(1);
        end
      end
      if (cnt_wr) begin
        nblk_q <= wr_plus1;
        ncnt_q <= wr_plus1;
        bcnt_q <= blen_q;
      end
      if (len_wr) begin
        blen_q <= wr_plus1;
        bcnt_q <= wr_plus1;
      end
    end
  end

  // R7
  bcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt_q <= blen_q);
  // R8
  ncnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ncnt_q <= nblk_q);
endmodule

// File: rtl/blk_rx_pack.sv
module blk_rx_pack
  import blk_xfer_pkg::*;
#(
  parameter int LVL_W = 6,
  parameter int AF_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             last_byte,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [AF_W-1:0]  af_level,
  input  logic             rx_valid,
  input  byte_t            rx_data,
  output logic             rx_ready,
  output logic             push,
  output word_t            wdata,
  output logic             step
);
  logic  half_q;
  byte_t low_q;
  logic  room;

  assign room     = (fifo_level <= LVL_W'(af_level));
  assign rx_ready = en && (half_q || room);
  assign step     = rx_valid && rx_ready;
  assign push     = step && (half_q || last_byte);
  assign wdata    = half_q ? {rx_data, low_q} : {{BYTE_W{1'b0}}, rx_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      low_q  <= '0;
    end else if (clr) begin
      half_q <= 1'b0;
    end else if (step) begin
      half_q <= !half_q && !last_byte;
      if (!half_q) low_q <= rx_data;
    end
  end
endmodule

// File: rtl/blk_tx_unpack.sv
module blk_tx_unpack
  import blk_xfer_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  en,
  input  logic  last_byte,
  input  logic  fifo_empty,
  input  word_t fifo_head,
  output logic  tx_valid,
  output byte_t tx_data,
  input  logic  tx_ready,
  output logic  pop,
  output logic  step
);
  logic half_q;

  assign tx_valid = en && !fifo_empty;
  assign tx_data  = half_q ? fifo_head[WORD_W-1:BYTE_W] : fifo_head[BYTE_W-1:0];
  assign step     = tx_valid && tx_ready;
  assign pop      = step && (half_q || last_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
    end else if (clr) begin
      half_q <= 1'b0;
    end else if (step) begin
      half_q <= !half_q && !last_byte;
    end
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int FIELD_W    = 11,
  localparam int CNT_W = FIELD_W + 1,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1),
  localparam int AF_W  = $clog2(FIFO_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_rx,
  input  logic             len_wr,
  input  logic             cnt_wr,
  input  logic [15:0]      reg_wdata,
  output logic [CNT_W-1:0] blen_live,
  output logic [CNT_W-1:0] nblk_live,
  output logic             xfer_active,
  output logic             xfer_done,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [AF_W-1:0]  af_level,
  output logic             fifo_push,
  output logic [15:0]      fifo_wdata,
  input  logic             fifo_empty,
  input  logic [15:0]      fifo_head,
  output logic             fifo_pop,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  output logic             rx_ready,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  input  logic             tx_ready
);
  logic      active_q, done_q;
  xfer_dir_e dir_q;
  logic      last_byte, last_blk;
  logic      rx_step, tx_step, step, end_c;
  logic      rx_en, tx_en;

  assign rx_en = active_q && (dir_q == DIR_RX);
  assign tx_en = active_q && (dir_q == DIR_TX);
  assign step  = rx_step || tx_step;
  assign end_c = step && last_byte && last_blk;

  blk_len_ctr #(.FIELD_W(FIELD_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .len_wr    (len_wr),
    .cnt_wr    (cnt_wr),
    .wr_field  (reg_wdata[FIELD_W-1:0]),
    .step      (step),
    .bcnt_o    (blen_live),
    .ncnt_o    (nblk_live),
    .last_byte (last_byte),
    .last_blk  (last_blk)
  );

  blk_rx_pack #(.LVL_W(LVL_W), .AF_W(AF_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (start),
    .en         (rx_en),
    .last_byte  (last_byte),
    .fifo_level (fifo_level),
    .af_level   (af_level),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_ready   (rx_ready),
    .push       (fifo_push),
    .wdata      (fifo_wdata),
    .step       (rx_step)
  );

  blk_tx_unpack u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (start),
    .en         (tx_en),
    .last_byte  (last_byte),
    .fifo_empty (fifo_empty),
    .fifo_head  (fifo_head),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_ready   (tx_ready),
    .pop        (fifo_pop),
    .step       (tx_step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      dir_q    <= DIR_TX;
      done_q   <= 1'b0;
    end else begin
      done_q <= end_c;
      if (start) begin
        active_q <= 1'b1;
        dir_q    <= start_rx ? DIR_RX : DIR_TX;
      end else if (end_c) begin
        active_q <= 1'b0;
      end
    end
  end

  assign xfer_active = active_q;
  assign xfer_done   = done_q;

  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !start) |=> (tx_valid && $stable(tx_data)));
  // R9
  push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_push && fifo_pop));
  // R8
  done_after_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(active_q));
endmodule

// File: tb/sim_blk_xfer_seq.sv
module sim_blk_xfer_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 0, start_rx = 0, len_wr = 0, cnt_wr = 0;
  logic [15:0] reg_wdata = '0;
  logic [11:0] blen_live, nblk_live;
  logic        xfer_active, xfer_done;
  logic [5:0]  fifo_level = '0;
  logic [4:0]  af_level = 5'd31;
  logic        fifo_push, fifo_pop;
  logic [15:0] fifo_wdata;
  logic        fifo_empty = 1'b1;
  logic [15:0] fifo_head = '0;
  logic        rx_valid = 0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 0;

  int errors = 0, checks = 0;
  bit finished = 0;

  logic [7:0]  src   [0:1023];
  logic [15:0] exp_w [0:1023];
  logic [15:0] txw   [0:1023];
  logic [7:0]  exp_b [0:1023];
  logic [15:0] mem   [0:31];

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_xfer_seq u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic wr_len(input logic [15:0] v);
    @(negedge clk); reg_wdata = v; len_wr = 1;
    @(negedge clk); len_wr = 0;
  endtask

  task automatic wr_cnt(input logic [15:0] v);
    @(negedge clk); reg_wdata = v; cnt_wr = 1;
    @(negedge clk); cnt_wr = 0;
  endtask

  function automatic logic [15:0] rx_word(input int blk, input int k, input int L);
    if (k + 1 < L) return {src[blk*L+k+1], src[blk*L+k]};
    return {8'h00, src[blk*L+k]};
  endfunction

  task automatic run_xfer(input bit rx, input int L, input int N, input int af, input int pct);
    int total, nw, W, done_b, cnt, hd, fed, cyc, in_blk, blk;
    bit hs, stall_prev;
    logic [7:0] stall_data;
    total = L * N; W = (L + 1) / 2; nw = 0;
    wr_len(16'(L - 1));
    wr_cnt(16'(N - 1));
    #1;
    chk(blen_live == 12'(L), "R2 byte counter reload on count write", blen_live, L);
    chk(nblk_live == 12'(N), "R2 block count load", nblk_live, N);
    if (rx) begin
      for (int i = 0; i < total; i++) src[i] = 8'($urandom);
      for (int b = 0; b < N; b++)
        for (int k = 0; k < L; k += 2) begin exp_w[nw] = rx_word(b, k, L); nw++; end
    end else begin
      for (int i = 0; i < N * W; i++) txw[i] = 16'($urandom);
      for (int b = 0; b < N; b++)
        for (int k = 0; k < L; k++) begin
          logic [15:0] w;
          w = txw[b*W + k/2];
          exp_b[b*L+k] = (k % 2 == 0) ? w[7:0] : w[15:8];
        end
    end
    af_level = 5'(af);
    @(negedge clk); start = 1; start_rx = rx;
    @(negedge clk); start = 0;
    done_b = 0; cnt = 0; hd = 0; fed = 0; cyc = 0; nw = 0; stall_prev = 0;
    fifo_level = '0; fifo_empty = 1'b1;
    while (done_b < total && cyc < 20000) begin
      cyc++;
      in_blk = done_b % L; blk = done_b / L;
      if (rx) begin
        rx_valid = ($urandom % 100) < pct;
        rx_data = src[done_b];
        fifo_level = 6'(cnt);
      end else begin
        tx_ready = ($urandom % 100) < pct;
        fifo_empty = (cnt == 0);
        fifo_head = mem[hd];
      end
      #1;
      chk(blen_live == 12'(L - in_blk), "R11 R7 live byte counter", blen_live, L - in_blk);
      chk(nblk_live == 12'(N - blk), "R11 R7 live block counter", nblk_live, N - blk);
      if (rx) begin
        if (in_blk % 2 == 0)
          chk(rx_ready == (cnt <= af), "R5 receive pause at boundary", rx_ready, cnt <= af);
        hs = rx_valid && rx_ready;
        chk(fifo_push == (hs && (in_blk % 2 == 1 || in_blk == L - 1)), "R3 push timing", fifo_push, hs);
        if (fifo_push) begin
          chk(fifo_wdata == exp_w[nw], "R3 packed word", fifo_wdata, exp_w[nw]);
          nw++;
        end
      end else begin
        if (cnt == 0) chk(tx_valid == 1'b0, "R6 transmit pause on empty", tx_valid, 0);
        if (stall_prev) begin
          chk(tx_valid && tx_data == stall_data, "R10 stalled byte held", tx_data, stall_data);
        end
        hs = tx_valid && tx_ready;
        if (hs) chk(tx_data == exp_b[done_b], "R4 transmit byte order", tx_data, exp_b[done_b]);
        chk(fifo_pop == (hs && (in_blk % 2 == 1 || in_blk == L - 1)), "R4 pop timing", fifo_pop, hs);
        stall_prev = tx_valid && !tx_ready;
        stall_data = tx_data;
      end
      @(posedge clk);
      if (rx) begin
        if (fifo_push) cnt++;
        if (cnt > 0 && ($urandom % 100) < pct) cnt--;
      end else begin
        int tail;
        tail = (hd + cnt) % 32;
        if (fifo_pop) begin hd = (hd + 1) % 32; cnt--; end
        if (fed < N * W && cnt < 32 && ($urandom % 100) < 60) begin
          mem[tail] = txw[fed]; fed++; cnt++;
        end
      end
      if (hs) done_b++;
      @(negedge clk);
    end
    rx_valid = 0; tx_ready = 0; fifo_empty = 1'b1;
    if (done_b < total) chk(0, "R8 transfer stuck", done_b, total);
    #1;
    chk(xfer_done == 1'b1, "R8 done strobe", xfer_done, 1);
    chk(xfer_active == 1'b0, "R8 active falls", xfer_active, 0);
    chk(nblk_live == 12'(N), "R8 block counter reload", nblk_live, N);
    chk(blen_live == 12'(L), "R7 byte counter reload", blen_live, L);
    @(negedge clk); #1;
    chk(xfer_done == 1'b0, "R8 done lasts one cycle", xfer_done, 0);
  endtask

  task automatic idle_check(input int exp_b_cnt, input int exp_n_cnt);
    rx_valid = 1; tx_ready = 1; fifo_empty = 0; fifo_level = '0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk(!rx_ready && !tx_valid && !fifo_push && !fifo_pop, "R9 idle no movement",
          {rx_ready, tx_valid, fifo_push, fifo_pop}, 0);
    end
    chk(blen_live == 12'(exp_b_cnt) && nblk_live == 12'(exp_n_cnt), "R9 idle counters held",
        {blen_live, nblk_live}, {12'(exp_b_cnt), 12'(exp_n_cnt)});
    rx_valid = 0; tx_ready = 0; fifo_empty = 1;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    #1;
    chk(blen_live == 0 && nblk_live == 0 && !xfer_active && !xfer_done, "R12 reset state",
        {blen_live, nblk_live}, 0);
    rst_n = 1;
    idle_check(0, 0);
    wr_len(16'hF803); #1;
    chk(blen_live == 12'd4, "R1 upper bits ignored", blen_live, 4);
    wr_len(16'h07FF); #1;
    chk(blen_live == 12'h800, "R1 maximum length", blen_live, 12'h800);
    run_xfer(1, 5, 2, 31, 100);
    run_xfer(1, 4, 3, 3, 30);
    run_xfer(0, 7, 2, 31, 70);
    run_xfer(0, 1, 3, 31, 50);
    run_xfer(1, 1, 1, 0, 80);
    run_xfer(0, 33, 2, 31, 90);
    idle_check(33, 2);
    for (int t = 0; t < 8; t++)
      run_xfer(bit'($urandom % 2), 1 + int'($urandom % 40), 1 + int'($urandom % 4),
               int'($urandom % 32), 30 + int'($urandom % 70));
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule